// File: doc/BRIEF.md
# Sequential Offset Register Loader

This block keeps the two threshold values that a FIFO's almost-empty and almost-full flag logic compares against. It has no address inputs. Software or a host controller reaches the four storage registers through the FIFO's own data ports. A shared active-low load strobe selects offset access instead of normal FIFO traffic. An internal rotating pointer decides which register each access touches.

Writes use the write clock. A write happens when the load strobe and the write enable are both low. Readback uses the read clock. A readback happens when the load strobe and both read enables are low, and the selected register then appears on a registered 9-bit output. The write side and the read side each have their own 2-bit pointer. Each pointer advances only on its own accesses and keeps its position when an access sequence is interrupted. The assembled empty and full thresholds are driven out continuously, at a width of log2(DEPTH) bits each.

Top module: `offset_seq_loader`

## Requirements
- R1: When `rst_n` is low, both low bytes become 8'h07, both high parts become zero, `dout` becomes 0, and both pointers return to slot 0. As a result, right after reset `ae_offset` and `af_offset` both equal 7.
- R2: Each `wr_clk` rising edge with `ld_n`=0 and `wr_en_n`=0 stores `din` into one slot and then advances the write pointer. The slots are used in this order: slot 0 is the empty low byte, slot 1 the empty high part, slot 2 the full low byte, slot 3 the full high part. The fifth load wraps back to slot 0.
- R3: The low bytes take `din[7:0]`. The high parts take only `din[HI_W-1:0]`, where HI_W = log2(DEPTH)-8. All other `din` bits are ignored.
- R4: A `wr_clk` edge with `ld_n`=1 or `wr_en_n`=1 leaves every slot and the write pointer unchanged. A later load then resumes at the next slot in the sequence.
- R5: Each `rd_clk` rising edge with `ld_n`=0, `rd_en_a_n`=0 and `rd_en_b_n`=0 loads `dout` with the slot chosen by the read pointer, zero-extended to 9 bits, and then advances the read pointer. The read order is the same as the write order in R2, and it wraps the same way.
- R6: A `rd_clk` edge without that readback condition leaves `dout` and the read pointer unchanged. The read pointer moves independently of the write pointer.
- R7: `ae_offset` always equals {empty high part, empty low byte}, and `af_offset` always equals {full high part, full low byte}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Active-low load strobe that selects offset access |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en_a_n | input | 1 | First active-low read enable |
| rd_en_b_n | input | 1 | Second active-low read enable |
| din | input | 9 | Write data |
| dout | output | 9 | Registered readback data |
| ae_offset | output | log2(DEPTH) | Almost-empty threshold |
| af_offset | output | log2(DEPTH) | Almost-full threshold |

## Verification
The bench first runs directed sequences. One is a complete four-slot load followed by a fifth load, which separates correct wrap-around from a pointer that saturates or clears. Another is a partial load that is interrupted, by the strobe going high or by the enable going high, and then resumed; this shows whether the pointer holds its position across the gap. Loads carry all-ones data, which exposes high parts that keep more bits than they should. Readbacks have idle gaps between them, so the read pointer's position can be checked separately from the write pointer's. A seeded random mix of loads, readbacks and idle cycles is then checked against a four-entry reference array.

// File: rtl/offset_seq_loader.sv
module offset_seq_loader #(
  parameter int DEPTH = 512,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              ld_n,
  input  logic              wr_en_n,
  input  logic              rd_en_a_n,
  input  logic              rd_en_b_n,
  input  logic [8:0]        din,
  output logic [8:0]        dout,
  output logic [ADDR_W-1:0] ae_offset,
  output logic [ADDR_W-1:0] af_offset
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [7:0] LO_RST = 8'h07;

  logic [7:0]      ae_lo, af_lo;
  logic [HI_W-1:0] ae_hi, af_hi;
  logic [1:0]      wr_sel, rd_sel;
  logic [7:0]      din_lo;
  logic [8:0]      rd_word;
  logic            wr_go, rd_go;

  assign din_lo = 8'(din & 9'h0FF);
  assign wr_go  = !ld_n && !wr_en_n;
  assign rd_go  = !ld_n && !rd_en_a_n && !rd_en_b_n;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_lo  <= LO_RST;
      af_lo  <= LO_RST;
      ae_hi  <= '0;
      af_hi  <= '0;
      wr_sel <= 2'd0;
    end else if (wr_go) begin
      case (wr_sel)
        2'd0: ae_lo <= din_lo;
        2'd1: ae_hi <= din_lo[HI_W-1:0];
        2'd2: af_lo <= din_lo;
        default: af_hi <= din_lo[HI_W-1:0];
      endcase
      wr_sel <= wr_sel + 2'd1;
    end
  end

  always_comb begin
    case (rd_sel)
      2'd0: rd_word = {1'b0, ae_lo};
      2'd1: rd_word = {{(9-HI_W){1'b0}}, ae_hi};
      2'd2: rd_word = {1'b0, af_lo};
      default: rd_word = {{(9-HI_W){1'b0}}, af_hi};
    endcase
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      dout   <= '0;
      rd_sel <= 2'd0;
    end else if (rd_go) begin
      dout   <= rd_word;
      rd_sel <= rd_sel + 2'd1;
    end
  end

  assign ae_offset = {ae_hi, ae_lo};
  assign af_offset = {af_hi, af_lo};
endmodule

module offset_seq_loader_chk #(
  parameter int ADDR_W = 9,
  localparam int HI_W = ADDR_W - 8
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst_n,
  input logic              ld_n,
  input logic              wr_en_n,
  input logic              rd_en_a_n,
  input logic              rd_en_b_n,
  input logic [HI_W-1:0]   din_hi,
  input logic [8:0]        dout,
  input logic [ADDR_W-1:0] ae_offset,
  input logic [ADDR_W-1:0] af_offset,
  input logic [1:0]        wr_sel,
  input logic [1:0]        rd_sel
);
  // R4
  ld_idle_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (ld_n || wr_en_n) |=> ($stable(ae_offset) && $stable(af_offset) && $stable(wr_sel)));

  // R2
  wr_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!ld_n && !wr_en_n) |=> (wr_sel == 2'($past(wr_sel) + 2'd1)));

  // R3
  hi_width_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!ld_n && !wr_en_n && wr_sel == 2'd1) |=>
      (ae_offset[ADDR_W-1:8] == $past(din_hi) && $stable(ae_offset[7:0])));

  // R6
  rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !(!ld_n && !rd_en_a_n && !rd_en_b_n) |=> ($stable(dout) && $stable(rd_sel)));

  // R5
  rd_zext_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!ld_n && !rd_en_a_n && !rd_en_b_n && rd_sel[0]) |=> (dout[8:HI_W] == '0));
endmodule

bind offset_seq_loader offset_seq_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .ld_n(ld_n),
  .wr_en_n(wr_en_n), .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n),
  .din_hi(din[ADDR_W-9:0]), .dout(dout), .ae_offset(ae_offset),
  .af_offset(af_offset), .wr_sel(wr_sel), .rd_sel(rd_sel)
);

// File: tb/test_offset_seq_loader.sv
module test_offset_seq_loader;
  localparam int DEPTH = 2048;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int HI_W = ADDR_W - 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_n = 1'b1, wr_en_n = 1'b1, rd_en_a_n = 1'b1, rd_en_b_n = 1'b1;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic [ADDR_W-1:0] ae_offset, af_offset;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [8:0] ref_slot [4];
  int wp, rp;
  logic [8:0] exp_dout;

  always #10 clk = ~clk;

  offset_seq_loader #(.DEPTH(DEPTH)) i_offset_seq_loader (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .ld_n(ld_n), .wr_en_n(wr_en_n),
    .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n), .din(din), .dout(dout),
    .ae_offset(ae_offset), .af_offset(af_offset));

  function automatic logic [8:0] keep_bits(int slot, logic [8:0] d);
    if (slot % 2 == 0) return {1'b0, d[7:0]};
    return d & 9'((1 << HI_W) - 1);
  endfunction

  function automatic logic [ADDR_W-1:0] join_off(logic [8:0] lo, logic [8:0] hi);
    return {hi[HI_W-1:0], lo[7:0]};
  endfunction

  task automatic model_reset();
    ref_slot[0] = 9'h007; ref_slot[2] = 9'h007;
    ref_slot[1] = 9'h000; ref_slot[3] = 9'h000;
    wp = 0; rp = 0; exp_dout = '0;
  endtask

  task automatic check(string tag);
    logic [ADDR_W-1:0] ea, ef;
    ea = join_off(ref_slot[0], ref_slot[1]);
    ef = join_off(ref_slot[2], ref_slot[3]);
    checks++;
    if (ae_offset !== ea || af_offset !== ef || dout !== exp_dout) begin
      errors++;
      $display("FAIL %s: ae=%h af=%h dout=%h expected ae=%h af=%h dout=%h",
               tag, ae_offset, af_offset, dout, ea, ef, exp_dout);
    end
  endtask

  task automatic cyc(logic l, logic w, logic ra, logic rb, logic [8:0] d, string tag);
    @(negedge clk);
    ld_n = l; wr_en_n = w; rd_en_a_n = ra; rd_en_b_n = rb; din = d;
    @(posedge clk);
    if (!l && !w) begin
      ref_slot[wp] = keep_bits(wp, d); wp = (wp + 1) % 4;
    end else if (!l && !ra && !rb) begin
      exp_dout = ref_slot[rp]; rp = (rp + 1) % 4;
    end
    @(negedge clk);
    ld_n = 1'b1; wr_en_n = 1'b1; rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
    check(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    check("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset");
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    model_reset();
    repeat (2) @(negedge clk);
    do_reset();
    // R2 partial load, then R4 interrupts
    cyc(0, 0, 1, 1, 9'h1A5, "R2 slot0");
    cyc(0, 0, 1, 1, 9'h1FF, "R3 slot1 masked");
    cyc(1, 0, 1, 1, 9'h0EE, "R4 strobe high");
    cyc(0, 1, 1, 1, 9'h0DD, "R4 enable high");
    cyc(0, 0, 1, 1, 9'h13C, "R4 resume slot2");
    cyc(0, 0, 1, 1, 9'h1FE, "R3 slot3 masked");
    cyc(0, 0, 1, 1, 9'h011, "R2 wrap slot0");
    // R5 readback with R6 gaps
    cyc(0, 1, 0, 1, 9'h000, "R6 one enable");
    cyc(0, 1, 0, 0, 9'h000, "R5 read slot0");
    cyc(1, 1, 0, 0, 9'h000, "R6 strobe high");
    cyc(0, 1, 0, 0, 9'h000, "R5 read slot1 zext");
    cyc(0, 1, 0, 0, 9'h000, "R5 read slot2");
    cyc(0, 1, 0, 0, 9'h000, "R5 read slot3");
    cyc(0, 1, 0, 0, 9'h000, "R5 read wrap");
    cyc(0, 0, 1, 1, 9'h077, "R6 write ptr independent");
    cyc(0, 1, 0, 0, 9'h000, "R5 read after write");
    for (int i = 0; i < 400; i++) begin
      logic l, w, ra, rb;
      l = ($urandom % 4) == 0 ? 1'b1 : 1'b0;
      w = $urandom % 2;
      ra = $urandom % 2;
      rb = ($urandom % 4) == 0 ? 1'b1 : 1'b0;
      if (!l && !w) begin ra = 1'b1; rb = 1'b1; end
      cyc(l, w, ra, rb, 9'($urandom), "R7 random");
    end
    do_reset();
    cyc(0, 0, 1, 1, 9'h155, "R1 ptr at slot0");
    cyc(0, 1, 0, 0, 9'h000, "R1 read ptr at slot0");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule